// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers seven interrupt requests for a small processor core and turns them into one interrupt line, one wake-up line and the strobes the core needs to enter its service routine. Three requests belong to the core group: an external pin edge, a port-change event and a timer-0 overflow. Four belong to the peripheral group: ADC conversion done, capture/compare, timer-2 match and timer-1 overflow. Every request latches a sticky flag. A flag reaches the core only when its own enable is set. Peripheral flags also need a group enable. A global enable then gates the final request.

The core takes an interrupt by pulsing an acknowledge input. The block then drops the global enable, emits a one-cycle push-return-address strobe and presents the fixed vector address. A return-from-interrupt pulse sets the global enable again. Software must clear the flags itself through the register port. The external pin and the port-change input are asynchronous and pass through synchronizers and edge detectors. The timer and peripheral events are single-cycle pulses in the block's clock domain.

Top module: `intr_two_level`

## Requirements
- R1: After reset the control, flag and enable registers read zero, and `irq_req`, `wake` and `push_ret` are low.
- R2: A source event sets its flag whatever the state of its enable, the group enable or the global enable.
- R3: For the core group (flag bits 0 to 2), `irq_req` is high exactly when the global enable is set and some core flag has its enable bit set.
- R4: A peripheral flag (bits 3 to 6) with its enable set raises `irq_req` only while both the group enable and the global enable are set.
- R5: An `irq_ack` pulse while `irq_req` is high clears the global enable by the next clock and gives a one-cycle `push_ret` pulse in that next cycle. `vec_addr` reads 0x0004. An `irq_ack` while `irq_req` is low changes nothing.
- R6: An `irq_reti` pulse sets the global enable by the next clock.
- R7: Acknowledge never clears a flag, so a flag left set raises `irq_req` again once the global enable returns. Writing zero to a flag bit clears it.
- R8: When an event and a software write of zero hit the same flag in the same cycle, the flag ends up set.
- R9: A qualifying edge on `ext_pin` sets flag bit 0 at the third rising clock edge after the change, and sets it only once per edge. Control bit 2 = 1 selects rising edges and 0 selects falling edges.
- R10: Either transition of `port_chg` sets flag bit 1 at the third rising clock edge after the change.
- R11: `wake` is high whenever an enabled flag would raise a request, with the group enable applied to peripheral flags and the global enable ignored.
- R12: Register map at `reg_addr`: 0 = control (bit 0 global enable, bit 1 group enable, bit 2 pin edge select); 1 = flags; 2 = enables. For flags and enables the bit order is 0 pin, 1 port change, 2 timer-0, 3 ADC, 4 capture/compare, 5 timer-2, 6 timer-1. Reads are combinational, and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_chg | input | 1 | Asynchronous port-change level |
| evt_tmr0 | input | 1 | Timer-0 overflow pulse |
| evt_periph | input | 4 | Peripheral pulses: 0 ADC, 1 capture/compare, 2 timer-2, 3 timer-1 |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_ack | input | 1 | Core takes the interrupt |
| irq_reti | input | 1 | Return from interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up from sleep |
| push_ret | output | 1 | Strobe to push the return address |
| vec_addr | output | 13 | Interrupt vector address |

## Verification
A wrong flag bit shows up on the next register read of address 1. It is visible on `wake` in the same cycle if the source is enabled. A global enable stuck high or low shows one clock after an acknowledge or a return, either as `irq_req` staying high or as it failing to come back. A wrong synchronizer depth or edge polarity moves flag bit 0 off the third clock edge, or lets the unselected edge through, and both faults show up on a read two or three cycles after the pin toggles. A lost set-versus-clear race leaves a zero in the flag register one cycle after the colliding write.

// File: rtl/intr_pkg.sv
package intr_pkg;
   localparam int NSRC   = 7;
   localparam int N_CORE = 3;
   localparam int N_PERI = NSRC - N_CORE;

   localparam int SRC_PIN  = 0;
   localparam int SRC_PORT = 1;
   localparam int SRC_TMR0 = 2;
   localparam int SRC_ADC  = 3;

   localparam int CTL_GLB  = 0;
   localparam int CTL_GRP  = 1;
   localparam int CTL_RISE = 2;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_FLAG = 2'd1,
      SEL_EN   = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic rise;
      logic grp;
      logic glb;
   } ctrl_t;
endpackage

// File: rtl/intr_edge_sync.sv
module intr_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       async_in,
   input  logic [1:0] edge_mask,
   output logic       pulse
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sh_q;
   logic                   prev_q;
   logic                   rise, fall;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("intr_edge_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[SYNC_STAGES-2:0], async_in};
         prev_q <= sh_q[LAST];
      end
   end

   assign rise  = sh_q[LAST] & ~prev_q;
   assign fall  = ~sh_q[LAST] & prev_q;
   assign pulse = (rise & edge_mask[0]) | (fall & edge_mask[1]);
endmodule

// File: rtl/intr_flag_bank.sv
module intr_flag_bank #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         wr_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] flags_o
);
   logic [N-1:0] flg_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               flg_q[i] <= 1'b0;
            else if (set_i[i])
               flg_q[i] <= 1'b1;
            else if (wr_i)
               flg_q[i] <= wdata_i[i];
         end
      end
   endgenerate

   assign flags_o = flg_q;
endmodule

// File: rtl/intr_gate.sv
module intr_gate #(
   parameter int N      = 7,
   parameter int N_CORE = 3
) (
   input  logic [N-1:0] flags_i,
   input  logic [N-1:0] en_i,
   input  logic         grp_en_i,
   input  logic         glb_en_i,
   output logic         pend_o,
   output logic         req_o
);
   logic [N-1:0] live;

   generate
      if (N_CORE > N) begin : g_bad_split
         $error("intr_gate: N_CORE exceeds N");
      end
      for (genvar i = 0; i < N; i++) begin : g_src
         if (i < N_CORE) begin : g_core
            assign live[i] = flags_i[i] & en_i[i];
         end else begin : g_peri
            assign live[i] = flags_i[i] & en_i[i] & grp_en_i;
         end
      end
   endgenerate

   assign pend_o = |live;
   assign req_o  = pend_o & glb_en_i;
endmodule

// File: rtl/intr_two_level.sv
module intr_two_level
   import intr_pkg::*;
#(
   parameter int              DATA_W      = 8,
   parameter int              ADDR_W      = 2,
   parameter int              VEC_W       = 13,
   parameter logic [VEC_W-1:0] VEC_ADDR   = 'h4,
   parameter int              SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_pin,
   input  logic              port_chg,
   input  logic              evt_tmr0,
   input  logic [N_PERI-1:0] evt_periph,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              irq_ack,
   input  logic              irq_reti,
   output logic              irq_req,
   output logic              wake,
   output logic              push_ret,
   output logic [VEC_W-1:0]  vec_addr
);
   generate
      if (DATA_W < NSRC) begin : g_bad_width
         $error("intr_two_level: DATA_W must hold all flag bits");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("intr_two_level: ADDR_W must be at least 2");
      end
      if (VEC_W < 3) begin : g_bad_vec
         $error("intr_two_level: VEC_W too narrow for the vector");
      end
   endgenerate

   ctrl_t         ctl_q;
   logic [NSRC-1:0] en_q;
   logic [NSRC-1:0] flags_q;
   logic [NSRC-1:0] set_vec;
   logic          take, take_q;
   logic          pin_pulse, port_pulse;
   logic          wr_ctrl, wr_flag, wr_en;
   reg_sel_e      sel;
   logic          glb_en_q;

   always_comb begin
      if (reg_addr > ADDR_W'(2)) sel = SEL_NONE;
      else                       sel = reg_sel_e'(reg_addr[1:0]);
   end

   assign wr_ctrl = reg_wr && (sel == SEL_CTRL);
   assign wr_flag = reg_wr && (sel == SEL_FLAG);
   assign wr_en   = reg_wr && (sel == SEL_EN);

   intr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_pin_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_in  (ext_pin),
      .edge_mask ({~ctl_q.rise, ctl_q.rise}),
      .pulse     (pin_pulse)
   );

   intr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_port_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_in  (port_chg),
      .edge_mask (2'b11),
      .pulse     (port_pulse)
   );

   assign set_vec = {evt_periph, evt_tmr0, port_pulse, pin_pulse};

   intr_flag_bank #(.N(NSRC)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .wr_i    (wr_flag),
      .wdata_i (reg_wdata[NSRC-1:0]),
      .flags_o (flags_q)
   );

   intr_gate #(.N(NSRC), .N_CORE(N_CORE)) u_gate (
      .flags_i  (flags_q),
      .en_i     (en_q),
      .grp_en_i (ctl_q.grp),
      .glb_en_i (ctl_q.glb),
      .pend_o   (wake),
      .req_o    (irq_req)
   );

   assign take = irq_ack & irq_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         en_q   <= '0;
         take_q <= 1'b0;
      end else begin
         take_q <= take;
         if (take)
            ctl_q.glb <= 1'b0;
         else if (irq_reti)
            ctl_q.glb <= 1'b1;
         else if (wr_ctrl)
            ctl_q.glb <= reg_wdata[CTL_GLB];
         if (wr_ctrl) begin
            ctl_q.grp  <= reg_wdata[CTL_GRP];
            ctl_q.rise <= reg_wdata[CTL_RISE];
         end
         if (wr_en)
            en_q <= reg_wdata[NSRC-1:0];
      end
   end

   assign glb_en_q = ctl_q.glb;

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_CTRL: begin
            reg_rdata[CTL_GLB]  = ctl_q.glb;
            reg_rdata[CTL_GRP]  = ctl_q.grp;
            reg_rdata[CTL_RISE] = ctl_q.rise;
         end
         SEL_FLAG: reg_rdata[NSRC-1:0] = flags_q;
         SEL_EN:   reg_rdata[NSRC-1:0] = en_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign push_ret = take_q;
   assign vec_addr = VEC_ADDR;
endmodule

// File: rtl/intr_two_level_chk.sv
module intr_two_level_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       irq_ack,
   input logic       irq_reti,
   input logic       irq_req,
   input logic       wake,
   input logic       push_ret,
   input logic       glb_en,
   input logic       evt_tmr0,
   input logic [3:0] evt_periph,
   input logic [6:0] flags
);
   // R5
   ack_clears_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> !glb_en);

   // R5
   push_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> push_ret);

   // R5
   push_only_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_ret |-> $past(irq_ack && irq_req));

   // R6
   reti_sets_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_reti && !(irq_ack && irq_req)) |=> glb_en);

   // R11
   req_implies_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> wake);

   // R8
   tmr0_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_tmr0 |=> flags[2]);

   // R2
   adc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_periph[0] |=> flags[3]);

   // R7
   flags_kept_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> (flags != 7'd0));
endmodule

bind intr_two_level intr_two_level_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_ack    (irq_ack),
   .irq_reti   (irq_reti),
   .irq_req    (irq_req),
   .wake       (wake),
   .push_ret   (push_ret),
   .glb_en     (glb_en_q),
   .evt_tmr0   (evt_tmr0),
   .evt_periph (evt_periph),
   .flags      (flags_q)
);

// File: tb/intr_two_level_bench.sv
module intr_two_level_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_pin = 1'b0;
   logic       port_chg = 1'b0;
   logic       evt_tmr0 = 1'b0;
   logic [3:0] evt_periph = 4'd0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       irq_ack = 1'b0;
   logic       irq_reti = 1'b0;
   logic       irq_req, wake, push_ret;
   logic [12:0] vec_addr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   intr_two_level u_intr_two_level (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_chg(port_chg),
      .evt_tmr0(evt_tmr0), .evt_periph(evt_periph), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_ack(irq_ack), .irq_reti(irq_reti), .irq_req(irq_req),
      .wake(wake), .push_ret(push_ret), .vec_addr(vec_addr)
   );

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic test_reset();
      logic [7:0] d;
      rd(2'd0, d); check("R1 ctrl", d, 0);
      rd(2'd1, d); check("R1 flags", d, 0);
      rd(2'd2, d); check("R1 enables", d, 0);
      check("R1 irq_req", irq_req, 0);
      check("R1 wake", wake, 0);
      check("R1 push_ret", push_ret, 0);
   endtask

   task automatic test_flags_no_enable();
      logic [7:0] d;
      evt_tmr0 = 1'b1; evt_periph = 4'hF;
      tick();
      evt_tmr0 = 1'b0; evt_periph = 4'h0;
      rd(2'd1, d); check("R2 flags set unmasked", d, 8'h7C);
      check("R2 no request", irq_req, 0);
      check("R11 no wake when disabled", wake, 0);
      wr(2'd1, 8'h00);
      rd(2'd1, d); check("R7 sw clear", d, 0);
   endtask

   task automatic test_core_req();
      logic [7:0] d;
      wr(2'd2, 8'h04);
      evt_tmr0 = 1'b1; tick(); evt_tmr0 = 1'b0;
      check("R11 wake with glb off", wake, 1);
      check("R3 no req with glb off", irq_req, 0);
      wr(2'd0, 8'h01);
      check("R3 core req", irq_req, 1);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      check("R5 push_ret pulse", push_ret, 1);
      check("R5 req dropped", irq_req, 0);
      check("R5 vector", vec_addr, 13'h0004);
      rd(2'd0, d); check("R5 glb cleared", d[0], 0);
      tick();
      check("R5 push_ret one cycle", push_ret, 0);
      rd(2'd1, d); check("R7 flag kept after ack", d, 8'h04);
      irq_reti = 1'b1; tick(); irq_reti = 1'b0;
      check("R6 glb back", irq_req, 1);
      check("R7 refire after reti", irq_req, 1);
      wr(2'd1, 8'h00);
      check("R7 cleared flag drops req", irq_req, 0);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      check("R5 ack without req no push", push_ret, 0);
      rd(2'd0, d); check("R5 ack without req keeps glb", d[0], 1);
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h00);
   endtask

   task automatic test_periph_group();
      wr(2'd2, 8'h08);
      wr(2'd0, 8'h01);
      evt_periph = 4'h1; tick(); evt_periph = 4'h0;
      check("R4 no req without group", irq_req, 0);
      check("R11 no wake without group", wake, 0);
      wr(2'd0, 8'h03);
      check("R4 req with group", irq_req, 1);
      wr(2'd0, 8'h02);
      check("R4 no req without glb", irq_req, 0);
      check("R11 wake ignores glb", wake, 1);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h00);
   endtask

   task automatic test_set_wins();
      logic [7:0] d;
      wr(2'd1, 8'h7F);
      reg_addr = 2'd1; reg_wdata = 8'h00; reg_wr = 1'b1; evt_tmr0 = 1'b1;
      tick();
      reg_wr = 1'b0; evt_tmr0 = 1'b0;
      rd(2'd1, d); check("R8 set beats clear", d, 8'h04);
      wr(2'd1, 8'h00);
   endtask

   task automatic test_ext_pin();
      logic [7:0] d;
      wr(2'd0, 8'h04);
      ext_pin = 1'b1;
      tick(2);
      rd(2'd1, d); check("R9 not yet at edge 2", d, 0);
      tick();
      rd(2'd1, d); check("R9 rise at edge 3", d, 8'h01);
      wr(2'd1, 8'h00);
      tick(5);
      rd(2'd1, d); check("R9 once per edge", d, 0);
      ext_pin = 1'b0;
      tick(5);
      rd(2'd1, d); check("R9 fall ignored in rise mode", d, 0);
      wr(2'd0, 8'h00);
      ext_pin = 1'b1;
      tick(5);
      rd(2'd1, d); check("R9 rise ignored in fall mode", d, 0);
      ext_pin = 1'b0;
      tick(2);
      rd(2'd1, d); check("R9 fall not yet", d, 0);
      tick();
      rd(2'd1, d); check("R9 fall at edge 3", d, 8'h01);
      wr(2'd1, 8'h00);
   endtask

   task automatic test_port_change();
      logic [7:0] d;
      port_chg = 1'b1;
      tick(2);
      rd(2'd1, d); check("R10 not yet", d, 0);
      tick();
      rd(2'd1, d); check("R10 rise sets", d, 8'h02);
      wr(2'd1, 8'h00);
      tick(3);
      port_chg = 1'b0;
      tick(3);
      rd(2'd1, d); check("R10 fall sets", d, 8'h02);
      wr(2'd1, 8'h00);
      rd(2'd1, d); check("R12 flags readback", d, 0);
      wr(2'd2, 8'h55);
      rd(2'd2, d); check("R12 enables readback", d, 8'h55);
      wr(2'd2, 8'h00);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      test_reset();
      test_flags_no_enable();
      test_core_req();
      test_periph_group();
      test_set_wins();
      test_ext_pin();
      test_port_change();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule